// File: doc/BRIEF.md
# Tunable Oscillator and Complex Mixer

This block shifts a complex baseband stream to a programmable intermediate frequency. Each accepted input sample advances a phase accumulator by a run-time tuning word. The phase that sample sees is turned into a cosine and a sine by a pipelined rotation CORDIC on adders and shifters, with no lookup table. The sample is then multiplied by that complex oscillator value to give real and imaginary outputs.

It sits at the end of an interpolation chain running at the IF sample rate. The accumulator is 28 bits wide, so at 61.44 Msps one tuning step is about 0.229 Hz. Samples arrive with a valid strobe and may have gaps between them. The phase moves only when a sample is taken, so the oscillator stays coherent with the data stream. A new tuning word is loaded with a separate strobe and changes the frequency without disturbing the accumulated phase.

Top module: `nco_mixer`

## Requirements
- R1: After reset, `outValid` is 0, both outputs are 0, the accumulated phase is 0 and the tuning word is 0.
- R2: The phase accumulator is 28 bits wide and wraps modulo 2^28. Sample n is mixed with the phase held before its own acceptance, and accepting it adds the current tuning word to the phase. The angle is 2*pi*phase/2^28.
- R3: In a cycle where `inValid` is 0, the phase does not change.
- R4: A word presented with `tuneLoad` is used for every phase increment from the first sample accepted in a later cycle. Loading a word never resets the phase.
- R5: The oscillator is correct in all four quadrants. The top two phase bits select the quadrant, and each output lies within 8 LSB of its ideal value.
- R6: `outI` equals I*cos - Q*sin and `outQ` equals I*sin + Q*cos, where I and Q are the signed 16-bit inputs and cos and sin are taken at the sample's phase.
- R7: Results are rounded to the nearest integer and saturated to the range -32768 to 32767. A result that lies beyond full scale comes out exactly at the limit.
- R8: Exactly one output is produced per accepted input, in input order. `outValid` rises 20 clock edges after the edge that accepted the sample.
- R9: While `outValid` is 0, `outI` and `outQ` keep the values of the last valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present this cycle |
| inI | input | 16 | Input in-phase sample, signed |
| inQ | input | 16 | Input quadrature sample, signed |
| tuneLoad | input | 1 | Capture `tuneWord` this cycle |
| tuneWord | input | 28 | Phase increment per sample, unsigned modulo 2^28 |
| outValid | output | 1 | Mixed output present |
| outI | output | 16 | Real mixer output, signed |
| outQ | output | 16 | Imaginary mixer output, signed |

## Verification
The latency property assumes that `inValid` is low for the whole reset period, because it compares `outValid` with `inValid` twenty edges earlier. The stimulus therefore holds `inValid` low from time zero until reset is released. The idle-hold and phase-hold properties assume the strobes are clean levels sampled at the clock. The driver changes inputs only on the falling edge and never raises `tuneLoad` in the same cycle as a sample. Stimulus covers back-to-back samples, gaps with tuning loads inside them, quarter-turn steps that visit every quadrant, full-scale inputs at 45 degrees, and a step just over half a turn so the accumulator wraps often.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  // Angle resolution used inside the rotator: a full turn is 2**ANGLE_W units.
  localparam int ANGLE_W = 20;

  typedef struct packed {
    logic accept;   // sample taken, advance phase
    logic tuneWr;   // capture new tuning word
    logic outWr;    // final pipeline stage holds a real sample
  } mixStrobe_t;

  // atan(2^-i) scaled to ANGLE_W units per full turn.
  function automatic int atanStep(input int idx);
    case (idx)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      14: return 10;
      15: return 5;
      16: return 3;
      17: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int CW  = 23,
  parameter int ZW  = 21,
  parameter int SBW = 34,
  parameter int IDX = 0
) (
  input  logic                  clk,
  input  logic signed [CW-1:0]  xIn,
  input  logic signed [CW-1:0]  yIn,
  input  logic signed [ZW-1:0]  zIn,
  input  logic [SBW-1:0]        sbIn,
  output logic signed [CW-1:0]  xOut,
  output logic signed [CW-1:0]  yOut,
  output logic signed [ZW-1:0]  zOut,
  output logic [SBW-1:0]        sbOut
);
  import nco_mix_pkg::*;

  localparam logic signed [ZW-1:0] STEP_ANG = ZW'(atanStep(IDX));

  logic signed [CW-1:0] xShift;
  logic signed [CW-1:0] yShift;

  assign xShift = xIn >>> IDX;
  assign yShift = yIn >>> IDX;

  always_ff @(posedge clk) begin
    if (zIn >= 0) begin
      xOut <= xIn - yShift;
      yOut <= yIn + xShift;
      zOut <= zIn - STEP_ANG;
    end else begin
      xOut <= xIn + yShift;
      yOut <= yIn - xShift;
      zOut <= zIn + STEP_ANG;
    end
    sbOut <= sbIn;
  end

endmodule

// File: rtl/nco_mix_ctrl.sv
module nco_mix_ctrl #(
  parameter int ITER = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     tuneLoad,
  output nco_mix_pkg::mixStrobe_t  strobe,
  output logic                     outValid
);
  // one bit per register stage: capture, ITER rotations, fold, multiply, output
  localparam int LAT = ITER + 4;

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.accept = inValid;
    strobe.tuneWr = tuneLoad;
    strobe.outWr  = validPipe[LAT-2];
  end

  assign outValid = validPipe[LAT-1];

endmodule

// File: rtl/nco_mix_dp.sv
module nco_mix_dp #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 28,
  parameter int ITER    = 16,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  nco_mix_pkg::mixStrobe_t   strobe,
  input  logic [PHASE_W-1:0]        tuneWord,
  input  logic signed [DATA_W-1:0]  inI,
  input  logic signed [DATA_W-1:0]  inQ,
  output logic signed [DATA_W-1:0]  outI,
  output logic signed [DATA_W-1:0]  outQ,
  output logic [PHASE_W-1:0]        phaseAcc
);
  import nco_mix_pkg::*;

  localparam int RES_W = ANGLE_W - 2;            // angle bits inside one quadrant
  localparam int ZW    = ANGLE_W + 1;
  localparam int OW    = FRAC_W + 3;             // oscillator word after guard drop
  localparam int CW    = OW + GUARD_W;           // rotator word with guard bits
  localparam int SBW   = 2 + 2 * DATA_W;         // quadrant plus I and Q
  localparam int PW    = DATA_W + OW;
  localparam int SW    = PW + 1;
  localparam longint UNIT = 64'd1 << (FRAC_W + GUARD_W);
  localparam logic signed [CW-1:0] X_START =
    CW'((UNIT * 64'd607253 + 64'd500000) / 64'd1000000);
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC_W - 1);
  localparam logic signed [SW-1:0] HI   = SW'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic signed [SW-1:0] LO   = ~HI;

  // phase accumulator and tuning register
  logic [PHASE_W-1:0] tuneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      tuneReg  <= '0;
    end else begin
      if (strobe.tuneWr) tuneReg  <= tuneWord;
      if (strobe.accept) phaseAcc <= phaseAcc + tuneReg;
    end
  end

  // capture stage: fold the angle into one quadrant
  logic signed [ZW-1:0] zCap;
  logic [SBW-1:0]       sbCap;
  logic [RES_W-1:0]     residual;

  assign residual = phaseAcc[PHASE_W-3 -: RES_W];

  always_ff @(posedge clk) begin
    zCap  <= $signed({{(ZW - RES_W){1'b0}}, residual});
    sbCap <= {phaseAcc[PHASE_W-1 -: 2], inI, inQ};
  end

  // rotation chain
  logic signed [CW-1:0] xc [0:ITER];
  logic signed [CW-1:0] yc [0:ITER];
  logic signed [ZW-1:0] zc [0:ITER];
  logic [SBW-1:0]       sc [0:ITER];

  assign xc[0] = X_START;
  assign yc[0] = '0;
  assign zc[0] = zCap;
  assign sc[0] = sbCap;

  for (genvar k = 0; k < ITER; k++) begin : g_rot
    nco_cordic_stage #(.CW(CW), .ZW(ZW), .SBW(SBW), .IDX(k)) uStage (
      .clk   (clk),
      .xIn   (xc[k]),
      .yIn   (yc[k]),
      .zIn   (zc[k]),
      .sbIn  (sc[k]),
      .xOut  (xc[k+1]),
      .yOut  (yc[k+1]),
      .zOut  (zc[k+1]),
      .sbOut (sc[k+1])
    );
  end

  // quadrant unfold
  logic signed [OW-1:0]     xEnd, yEnd, cosR, sinR;
  logic [1:0]               quadEnd;
  logic signed [DATA_W-1:0] iEnd, qEnd, iFold, qFold;

  assign xEnd    = xc[ITER][CW-1:GUARD_W];
  assign yEnd    = yc[ITER][CW-1:GUARD_W];
  assign quadEnd = sc[ITER][SBW-1 -: 2];
  assign iEnd    = $signed(sc[ITER][2*DATA_W-1 -: DATA_W]);
  assign qEnd    = $signed(sc[ITER][DATA_W-1:0]);

  always_ff @(posedge clk) begin
    unique case (quadEnd)
      2'd0: begin cosR <= xEnd;  sinR <= yEnd;  end
      2'd1: begin cosR <= -yEnd; sinR <= xEnd;  end
      2'd2: begin cosR <= -xEnd; sinR <= -yEnd; end
      default: begin cosR <= yEnd; sinR <= -xEnd; end
    endcase
    iFold <= iEnd;
    qFold <= qEnd;
  end

  // complex multiply
  logic signed [PW-1:0] pIc, pQs, pIs, pQc;

  always_ff @(posedge clk) begin
    pIc <= PW'(iFold) * PW'(cosR);
    pQs <= PW'(qFold) * PW'(sinR);
    pIs <= PW'(iFold) * PW'(sinR);
    pQc <= PW'(qFold) * PW'(cosR);
  end

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + HALF) >>> FRAC_W;
    if (r > HI)      return HI[DATA_W-1:0];
    else if (r < LO) return LO[DATA_W-1:0];
    else             return r[DATA_W-1:0];
  endfunction

  logic signed [SW-1:0] sumRe, sumIm;

  assign sumRe = SW'(pIc) - SW'(pQs);
  assign sumIm = SW'(pIs) + SW'(pQc);

  always_ff @(posedge clk) begin
    if (rst) begin
      outI <= '0;
      outQ <= '0;
    end else if (strobe.outWr) begin
      outI <= roundSat(sumRe);
      outQ <= roundSat(sumIm);
    end
  end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 28,
  parameter int ITER    = 16,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic signed [DATA_W-1:0]  inI,
  input  logic signed [DATA_W-1:0]  inQ,
  input  logic                      tuneLoad,
  input  logic [PHASE_W-1:0]        tuneWord,
  output logic                      outValid,
  output logic signed [DATA_W-1:0]  outI,
  output logic signed [DATA_W-1:0]  outQ
);
  import nco_mix_pkg::*;

  mixStrobe_t         strobe;
  logic [PHASE_W-1:0] phaseAcc;

  nco_mix_ctrl #(.ITER(ITER)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .tuneLoad (tuneLoad),
    .strobe   (strobe),
    .outValid (outValid)
  );

  nco_mix_dp #(
    .DATA_W (DATA_W), .PHASE_W (PHASE_W), .ITER (ITER),
    .FRAC_W (FRAC_W), .GUARD_W (GUARD_W)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tuneWord (tuneWord),
    .inI      (inI),
    .inQ      (inQ),
    .outI     (outI),
    .outQ     (outQ),
    .phaseAcc (phaseAcc)
  );

endmodule

// File: rtl/nco_mix_checker.sv
module nco_mix_checker #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 28,
  parameter int ITER    = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      inValid,
  input logic                      outValid,
  input logic signed [DATA_W-1:0]  outI,
  input logic signed [DATA_W-1:0]  outQ,
  input logic [PHASE_W-1:0]        phaseAcc
);
  localparam int LAT = ITER + 4;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!outValid && outI == '0 && outQ == '0 && phaseAcc == '0));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phaseAcc));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid, LAT));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outI) && $stable(outQ)));

endmodule

bind nco_mixer nco_mix_checker #(
  .DATA_W (DATA_W), .PHASE_W (PHASE_W), .ITER (ITER)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outI     (outI),
  .outQ     (outQ),
  .phaseAcc (phaseAcc)
);

// File: tb/nco_mixer_test.sv
module nco_mixer_test;
  localparam int  LAT = 20;
  localparam int  TOL = 8;
  localparam real TWO_PI = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inValid = 1'b0;
  logic               tuneLoad = 1'b0;
  logic signed [15:0] inI = '0;
  logic signed [15:0] inQ = '0;
  logic [27:0]        tuneWord = '0;
  logic               outValid;
  logic signed [15:0] outI, outQ;

  nco_mixer uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .tuneLoad(tuneLoad), .tuneWord(tuneWord),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    expI;
    int    expQ;
    int    sentCyc;
    string tag;
  } item_t;

  item_t       sb[$];
  int          vectors = 0;
  int          miscompares = 0;
  int          cyc = 0;
  logic [27:0] modelPhase = '0;
  logic [27:0] modelStep = '0;
  bit          done = 1'b0;
  bit          seenOut = 1'b0;
  int          lastI = 0;
  int          lastQ = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int roundClamp(input real v);
    int r;
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(-v + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one accepted sample per call, expected value pushed to the scoreboard
  task automatic sendSample(input int i, input int q, input string tag);
    real   ang;
    item_t it;
    @(negedge clk);
    ang = TWO_PI * real'(modelPhase) / 268435456.0;
    it.expI    = roundClamp(real'(i) * $cos(ang) - real'(q) * $sin(ang));
    it.expQ    = roundClamp(real'(i) * $sin(ang) + real'(q) * $cos(ang));
    it.sentCyc = cyc;
    it.tag     = tag;
    sb.push_back(it);
    tuneLoad   = 1'b0;
    inI        = 16'(i);
    inQ        = 16'(q);
    inValid    = 1'b1;
    modelPhase = modelPhase + modelStep;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid  = 1'b0;
      tuneLoad = 1'b0;
    end
  endtask

  task automatic loadTune(input logic [27:0] w);
    @(negedge clk);
    inValid   = 1'b0;
    tuneLoad  = 1'b1;
    tuneWord  = w;
    modelStep = w;
  endtask

  // monitor: pops the scoreboard whenever the design presents a result
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "output without input", 1, 0);
        end else begin
          item_t it;
          int    dI, dQ;
          it = sb.pop_front();
          dI = int'(outI) - it.expI;
          dQ = int'(outQ) - it.expQ;
          check(dI <= TOL && dI >= -TOL, it.tag, "outI", int'(outI), it.expI);
          check(dQ <= TOL && dQ >= -TOL, it.tag, "outQ", int'(outQ), it.expQ);
          check(cyc - it.sentCyc == LAT, "R8", "latency", cyc - it.sentCyc, LAT);
        end
        lastI   = int'(outI);
        lastQ   = int'(outQ);
        seenOut = 1'b1;
      end else if (seenOut) begin
        check(int'(outI) == lastI, "R9", "outI held", int'(outI), lastI);
        check(int'(outQ) == lastQ, "R9", "outQ held", int'(outQ), lastQ);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R8 watchdog: cycle %0d expected below %0d", cyc, 20000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(outI == 16'sd0, "R1", "outI in reset", int'(outI), 0);
    check(outQ == 16'sd0, "R1", "outQ in reset", int'(outQ), 0);
    rst = 1'b0;
    idle(2);

    // R6 and R1: zero step keeps phase at zero, output equals input
    sendSample(1000, 0, "R6");
    sendSample(0, 1000, "R6");
    sendSample(-20000, 12345, "R6");
    sendSample(32767, -32768, "R6");
    idle(3);

    // R5: quarter-turn step walks through every quadrant
    loadTune(28'h4000000);
    for (int k = 0; k < 8; k++) sendSample(10000, 3000, "R5");
    idle(2);

    // R2: arbitrary step with varied data, back to back
    loadTune(28'h0123457);
    for (int k = 0; k < 24; k++)
      sendSample((k * 7919) % 40000 - 20000, 15000 - (k * 4391) % 30000, "R2");

    // R3 and R4: gaps hold the phase; a load in a gap changes the step only
    idle(5);
    sendSample(12000, -9000, "R3");
    idle(4);
    loadTune(28'h0800000);
    idle(3);
    sendSample(-7000, 21000, "R4");
    sendSample(25000, 4000, "R4");
    idle(6);
    sendSample(-16000, -16000, "R3");

    // R7: full-scale inputs on a 45-degree step must saturate
    loadTune(28'h2000000);
    for (int k = 0; k < 8; k++) sendSample(32767, -32768, "R7");
    for (int k = 0; k < 8; k++) sendSample(-32768, 32767, "R7");

    // R2 wrap: step just over half a turn
    loadTune(28'h8000001);
    for (int k = 0; k < 30; k++) sendSample(20000 - k * 900, 8000 + k * 500, "R2");

    idle(LAT + 10);
    check(sb.size() == 0, "R8", "outputs outstanding", sb.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule